// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Rights

This block holds recently used virtual-to-physical page translations and checks every access against the rights stored with its translation. A lookup presents a virtual address and an access kind (read, write or instruction fetch). The virtual page number is compared against every stored tag at once, and in the same cycle the block reports one of three outcomes: a hit with the physical address, a miss when no valid tag matches, or a rights fault when a tag matches but its rights forbid the access. The physical address is the stored physical page number joined to the untranslated 12-bit page offset.

Each slot also keeps a reference bit and a dirty bit. A completed access sets the reference bit. A completed write also sets the dirty bit. A single-cycle clear input drops all reference bits together. New translations arrive from a page walker over a valid/ready channel. The block picks the slot to replace, and in the cycle of acceptance it reports the translation being evicted and whether that page was written. Walking the page table and handling faults are left to other logic.

Top module: `tlb_prot`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses; with no request present lk_hit, lk_miss, lk_fault and evict_valid are low and fill_ready is high.
- R2: A lookup whose page number matches a valid slot and whose access is permitted raises lk_hit in the same cycle, with lk_paddr equal to that slot's physical page number above the unchanged low 12 address bits; any slot can hold any page.
- R3: A lookup with no matching valid slot raises lk_miss and changes no stored state.
- R4: Rights are encoded 2'b00 none, 2'b01 read-only, 2'b10 read/write, 2'b11 execute-only. Access kinds are encoded 2'b00 read, 2'b01 write, 2'b10 fetch, 2'b11 reserved. Read-only permits reads, read/write permits reads and writes, execute-only permits fetches, and none and the reserved kind permit nothing. A matching access that is not permitted raises lk_fault instead of lk_hit.
- R5: A permitted write hit sets the slot's dirty bit; a faulting access does not. A refill clears the dirty bit of the slot it writes, and the dirty bit is seen at evict_dirty when that slot is later replaced.
- R6: A permitted hit sets the slot's reference bit; a faulting access does not. ref_clear clears every reference bit in one cycle, except that a permitted hit in the same cycle still sets its own slot's bit. A refill leaves its slot's reference bit clear.
- R7: A refill of a new page chooses the lowest-indexed invalid slot. If every slot is valid, it chooses the lowest-indexed slot with a clear reference bit. If all reference bits are set, it chooses the slot under a round-robin pointer, which starts at 0 and advances by one, wrapping, each time it is used.
- R8: A refill whose page number already sits in a valid slot overwrites that slot with the new physical page and rights, so no page number is ever held twice.
- R9: fill_ready is low in any cycle where lk_valid is high, because lookups take priority. A refill is taken only on a clock edge where fill_valid and fill_ready are both high, and it is seen by lookups from the following cycle.
- R10: In the cycle a refill is taken over a slot that holds a valid translation, evict_valid is high and evict_vpn and evict_dirty give that slot's page number and dirty bit.
- R11: While lk_valid is high exactly one of lk_hit, lk_miss and lk_fault is high; while it is low none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present this cycle |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 00 read, 01 write, 10 fetch, 11 reserved |
| lk_hit | output | 1 | Translation found and access permitted |
| lk_miss | output | 1 | No valid slot holds the page |
| lk_fault | output | 1 | Page found but access forbidden by its rights |
| lk_paddr | output | PA_W | Translated physical address, meaningful with lk_hit |
| fill_valid | input | 1 | Walker offers a translation |
| fill_ready | output | 1 | Block can take the offered translation this cycle |
| fill_vpn | input | VA_W-12 | Virtual page number of the offered translation |
| fill_ppn | input | PA_W-12 | Physical page number of the offered translation |
| fill_rights | input | 2 | Rights: 00 none, 01 read-only, 10 read/write, 11 execute-only |
| ref_clear | input | 1 | Clear all reference bits |
| evict_valid | output | 1 | Accepted refill displaces a valid translation |
| evict_vpn | output | VA_W-12 | Page number of the displaced translation |
| evict_dirty | output | 1 | Displaced page had been written |

## Verification
The bench builds the block with ENTRIES set to 4 and the default 32-bit virtual and 28-bit physical addresses. Four slots fill after four refills, so the three stages of victim choice can each be reached in a few cycles. These are the invalid slot, the lowest slot with a clear reference bit, and the round-robin pointer in its first and second positions. The same setting also brings the interaction of ref_clear with a same-cycle hit within reach. The default of 64 slots changes only the width of the compare and the encoders, not the order in which victims are chosen.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    RGT_NONE = 2'b00,
    RGT_RO   = 2'b01,
    RGT_RW   = 2'b10,
    RGT_EXEC = 2'b11
  } rights_t;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_t;

endpackage

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
  import tlb_pkg::*;
(
  input  logic [1:0] rights,
  input  logic [1:0] kind,
  output logic       allow
);

  rights_t r;
  acc_t    a;

  always_comb begin
    r = rights_t'(rights);
    a = acc_t'(kind);
    unique case (r)
      RGT_RO:   allow = (a == ACC_READ);
      RGT_RW:   allow = (a == ACC_READ) || (a == ACC_WRITE);
      RGT_EXEC: allow = (a == ACC_FETCH);
      default:  allow = 1'b0;
    endcase
  end

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N      = 64,
  parameter int VPN_W  = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [VPN_W-1:0]        key,
  input  logic [N-1:0][VPN_W-1:0] tags,
  input  logic [N-1:0]            valid,
  output logic [N-1:0]            match,
  output logic                    any,
  output logic [IDX_W-1:0]        idx
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N      = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  input  logic [N-1:0]     refb,
  input  logic             advance,
  output logic [IDX_W-1:0] victim,
  output logic             use_rr
);

  logic [IDX_W-1:0] rr_ptr;
  logic [IDX_W-1:0] first_inv;
  logic [IDX_W-1:0] first_unref;
  logic             have_inv;
  logic             have_unref;

  always_comb begin
    first_inv   = '0;
    first_unref = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) first_inv   = IDX_W'(i);
      if (!refb[i])  first_unref = IDX_W'(i);
    end
  end

  assign have_inv   = ~&valid;
  assign have_unref = ~&refb;
  assign use_rr     = !have_inv && !have_unref;
  assign victim     = have_inv   ? first_inv   :
                      have_unref ? first_unref : rr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (advance) begin
      rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  AST_VICTIM_PREFERS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    have_inv |-> !valid[victim]); // R7

endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 28,
  parameter int OFF_W   = 12,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_kind,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_fault,
  output logic [PA_W-1:0]  lk_paddr,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic [1:0]       fill_rights,
  input  logic             ref_clear,
  output logic             evict_valid,
  output logic [VPN_W-1:0] evict_vpn,
  output logic             evict_dirty
);

  logic [ENTRIES-1:0][VPN_W-1:0] ent_tag;
  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
  logic [ENTRIES-1:0][1:0]       ent_rights;
  logic [ENTRIES-1:0]            ent_valid;
  logic [ENTRIES-1:0]            ent_ref;
  logic [ENTRIES-1:0]            ent_dirty;

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] l_match;
  logic               l_any;
  logic [IDX_W-1:0]   l_idx;
  logic [ENTRIES-1:0] f_match;
  logic               f_any;
  logic [IDX_W-1:0]   f_idx;
  logic [IDX_W-1:0]   v_idx;
  logic               v_use_rr;
  logic               allow;
  logic               lk_ok;
  logic               fill_fire;
  logic [IDX_W-1:0]   w_idx;

  assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];

  tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W)) u_cam_lookup (
    .key   (lk_vpn),
    .tags  (ent_tag),
    .valid (ent_valid),
    .match (l_match),
    .any   (l_any),
    .idx   (l_idx)
  );

  tlb_cam #(.N(ENTRIES), .VPN_W(VPN_W)) u_cam_fill (
    .key   (fill_vpn),
    .tags  (ent_tag),
    .valid (ent_valid),
    .match (f_match),
    .any   (f_any),
    .idx   (f_idx)
  );

  tlb_perm_chk u_perm (
    .rights (ent_rights[l_idx]),
    .kind   (lk_kind),
    .allow  (allow)
  );

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (ent_valid),
    .refb    (ent_ref),
    .advance (fill_fire && !f_any && v_use_rr),
    .victim  (v_idx),
    .use_rr  (v_use_rr)
  );

  // Lookup outcome, all combinational
  assign lk_ok    = lk_valid && l_any && allow;
  assign lk_hit   = lk_ok;
  assign lk_miss  = lk_valid && !l_any;
  assign lk_fault = lk_valid && l_any && !allow;
  assign lk_paddr = {l_any ? ent_ppn[l_idx] : {PPN_W{1'b0}}, lk_vaddr[OFF_W-1:0]};

  // Refill channel: lookups win the state-update port
  assign fill_ready  = !lk_valid;
  assign fill_fire   = fill_valid && fill_ready;
  assign w_idx       = f_any ? f_idx : v_idx;
  assign evict_valid = fill_fire && ent_valid[w_idx];
  assign evict_vpn   = ent_tag[w_idx];
  assign evict_dirty = evict_valid && ent_dirty[w_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid  <= '0;
      ent_ref    <= '0;
      ent_dirty  <= '0;
      ent_tag    <= '0;
      ent_ppn    <= '0;
      ent_rights <= '0;
    end else begin
      if (ref_clear) ent_ref <= '0;
      if (lk_ok) begin
        ent_ref[l_idx] <= 1'b1;
        if (acc_t'(lk_kind) == ACC_WRITE) ent_dirty[l_idx] <= 1'b1;
      end
      if (fill_fire) begin
        ent_valid[w_idx]  <= 1'b1;
        ent_ref[w_idx]    <= 1'b0;
        ent_dirty[w_idx]  <= 1'b0;
        ent_tag[w_idx]    <= fill_vpn;
        ent_ppn[w_idx]    <= fill_ppn;
        ent_rights[w_idx] <= fill_rights;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({lk_hit, lk_miss, lk_fault}) == 1); // R11
  AST_NO_DUP_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones(l_match) <= 1); // R8
  AST_FAULT_KEEPS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |=> $stable(ent_dirty)); // R5
  AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_miss && !ref_clear) |=> ($stable(ent_valid) && $stable(ent_ref) && $stable(ent_dirty))); // R3
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire |=> (ent_valid[$past(w_idx)] && ent_tag[$past(w_idx)] == $past(fill_vpn))); // R9

endmodule

// File: tb/test_tlb_prot.sv
`timescale 1ns/1ps
module test_tlb_prot;

  localparam int ENTRIES = 4;
  localparam int VA_W = 32;
  localparam int PA_W = 28;
  localparam int VPN_W = VA_W - 12;
  localparam int PPN_W = PA_W - 12;

  localparam logic [1:0] K_RD = 2'b00, K_WR = 2'b01, K_FE = 2'b10, K_RS = 2'b11;
  localparam logic [1:0] P_NO = 2'b00, P_RO = 2'b01, P_RW = 2'b10, P_EX = 2'b11;
  localparam int O_MISS = 0, O_HIT = 1, O_FAULT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic [1:0] lk_kind = '0;
  logic lk_hit, lk_miss, lk_fault;
  logic [PA_W-1:0] lk_paddr;
  logic fill_valid = 1'b0;
  logic fill_ready;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [1:0] fill_rights = '0;
  logic ref_clear = 1'b0;
  logic evict_valid;
  logic [VPN_W-1:0] evict_vpn;
  logic evict_dirty;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tlb_prot #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)) i_tlb_prot (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_paddr(lk_paddr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_rights(fill_rights), .ref_clear(ref_clear),
    .evict_valid(evict_valid), .evict_vpn(evict_vpn), .evict_dirty(evict_dirty)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] outc(input int o);
    return (o == O_HIT) ? 3'b100 : (o == O_MISS) ? 3'b010 : 3'b001;
  endfunction

  // One lookup; outcome and address sampled before the edge that applies updates
  task automatic lookup(input string req, input logic [VPN_W-1:0] vpn, input logic [11:0] off,
                        input logic [1:0] kind, input int o, input logic [PPN_W-1:0] eppn,
                        input bit clr = 1'b0);
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {vpn, off}; lk_kind = kind; ref_clear = clr;
    #1;
    chk({req, " outcome"}, {lk_hit, lk_miss, lk_fault}, outc(o));
    chk("R9 ready low during lookup", fill_ready, 1'b0);
    if (o == O_HIT) chk({req, " paddr"}, lk_paddr, {eppn, off});
    @(posedge clk); #1;
    lk_valid = 1'b0; ref_clear = 1'b0;
  endtask

  task automatic fill(input string req, input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                      input logic [1:0] rts, input bit ev, input logic [VPN_W-1:0] ev_vpn,
                      input bit ev_dirty);
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rights = rts;
    #1;
    chk("R9 ready when idle", fill_ready, 1'b1);
    chk({req, " evict_valid"}, evict_valid, ev);
    if (ev) begin
      chk({req, " evict_vpn"}, evict_vpn, ev_vpn);
      chk({req, " evict_dirty"}, evict_dirty, ev_dirty);
    end
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  localparam logic [VPN_W-1:0] VA = 20'h00010, VB = 20'h00200, VC = 20'h03000, VD = 20'h40000,
                               VE = 20'h00E0E, VF = 20'h0F0F0, VG = 20'h12345, VH = 20'hABCDE,
                               VI = 20'h55555, VX = 20'h99999;

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 idle outcome", {lk_hit, lk_miss, lk_fault}, 3'b000);
    chk("R11 idle outcome", {lk_hit, lk_miss, lk_fault}, 3'b000);
    chk("R1 fill_ready", fill_ready, 1'b1);
    chk("R1 evict_valid", evict_valid, 1'b0);
    lookup("R1 empty miss", VA, 12'h123, K_RD, O_MISS, '0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = {VA, 12'h000}; lk_kind = K_RD;
    fill_valid = 1'b1; fill_vpn = VA; fill_ppn = 16'h0A0A; fill_rights = P_RW;
    #1;
    chk("R9 ready low with lookup", fill_ready, 1'b0);
    chk("R10 no evict when blocked", evict_valid, 1'b0);
    @(posedge clk); #1;
    lk_valid = 1'b0; fill_valid = 1'b0;
    lookup("R9 blocked fill not stored", VA, 12'h000, K_RD, O_MISS, '0);
  endtask

  task automatic t_fill_and_rights();
    fill("R7 first invalid A", VA, 16'h0A0A, P_RW, 1'b0, '0, 1'b0);
    fill("R7 first invalid B", VB, 16'h0B0B, P_RO, 1'b0, '0, 1'b0);
    fill("R7 first invalid C", VC, 16'h0C0C, P_EX, 1'b0, '0, 1'b0);
    fill("R7 first invalid D", VD, 16'h0D0D, P_NO, 1'b0, '0, 1'b0);
    lookup("R2 read A", VA, 12'hFFF, K_RD, O_HIT, 16'h0A0A);
    lookup("R2 write A", VA, 12'h001, K_WR, O_HIT, 16'h0A0A);
    lookup("R4 write to read-only B", VB, 12'h000, K_WR, O_FAULT, '0);
    lookup("R2 fetch C", VC, 12'h7A5, K_FE, O_HIT, 16'h0C0C);
    lookup("R4 read exec-only C", VC, 12'h000, K_RD, O_FAULT, '0);
    lookup("R4 read none D", VD, 12'h000, K_RD, O_FAULT, '0);
    lookup("R4 fetch read/write A", VA, 12'h000, K_FE, O_FAULT, '0);
    lookup("R4 reserved kind A", VA, 12'h000, K_RS, O_FAULT, '0);
    lookup("R3 unknown page", VX, 12'h000, K_RD, O_MISS, '0);
  endtask

  task automatic t_unref_victim();
    // refs: A and C set; B and D clear (faults do not set: R6)
    fill("R6 R7 lowest unreferenced B", VE, 16'h0E0E, P_RW, 1'b1, VB, 1'b0);
    fill("R7 new fill left unreferenced", VF, 16'h0F0F, P_RW, 1'b1, VE, 1'b0);
    lookup("R3 evicted page misses", VB, 12'h000, K_RD, O_MISS, '0);
  endtask

  task automatic t_overwrite_and_rr();
    lookup("R4 write none D", VD, 12'h000, K_WR, O_FAULT, '0);
    fill("R8 same tag D overwrite", VD, 16'h0D1D, P_RO, 1'b1, VD, 1'b0);
    lookup("R8 new ppn for D", VD, 12'h0C4, K_RD, O_HIT, 16'h0D1D);
    lookup("R4 write read-only D", VD, 12'h000, K_WR, O_FAULT, '0);
    lookup("R2 read F", VF, 12'h010, K_RD, O_HIT, 16'h0F0F);
    fill("R7 R5 round robin slot 0 dirty", VG, 16'h0101, P_RW, 1'b1, VA, 1'b1);
    lookup("R2 read G", VG, 12'h000, K_RD, O_HIT, 16'h0101);
    fill("R7 round robin slot 1", VH, 16'h0202, P_RW, 1'b1, VF, 1'b0);
  endtask

  task automatic t_ref_clear();
    lookup("R2 read H", VH, 12'h000, K_RD, O_HIT, 16'h0202);
    lookup("R2 fetch C again", VC, 12'h000, K_FE, O_HIT, 16'h0C0C);
    lookup("R2 read D", VD, 12'h000, K_RD, O_HIT, 16'h0D1D);
    lookup("R6 hit with clear", VG, 12'h000, K_RD, O_HIT, 16'h0101, 1'b1);
    fill("R6 clear spares concurrent hit", VI, 16'h0303, P_RW, 1'b1, VH, 1'b0);
    fill("R5 fault never dirtied D", VD, 16'h0D2D, P_RW, 1'b1, VD, 1'b0);
    lookup("R8 D holds new rights", VD, 12'h000, K_WR, O_HIT, 16'h0D2D);
    lookup("R8 I present", VI, 12'h000, K_RD, O_HIT, 16'h0303);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_backpressure();
    t_fill_and_rights();
    t_unref_victim();
    t_overwrite_and_rr();
    t_ref_clear();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule